// File: doc/BRIEF.md
# SIMD pixel pack/expand unit

This datapath turns partitioned pixel data into other lane formats in one clocked step. A start pulse loads a 9-bit operation code, two 64-bit source operands and a 5-bit scale value. The scale value is the scale field of the graphics status register, which sits in that register's bits 7..3.

Three of the operations are saturating packs that narrow signed fixed-point lanes. The 16-bit pack produces unsigned bytes. The 32-bit pack produces unsigned bytes and also slides the first operand along. The fixed pack produces signed 16-bit values. Each pack has its own binary point. The expand operation widens unsigned bytes into 16-bit fixed-point lanes. The merge operation interleaves the bytes of two 32-bit sources.

The result appears one clock after the start pulse, together with a one-cycle valid pulse. The result then holds until the next start. A code outside the five supported ones gives a zero result and a one-cycle illegal flag.

Top module: `pxfmt_unit`

## Requirements
- R1: Operation codes are 0x03B (16-bit pack), 0x03A (32-bit pack), 0x03D (fixed pack), 0x04D (expand) and 0x04B (merge). Any other code is illegal.
- R2: The 16-bit pack treats rs2 as four signed 16-bit lanes, lane i in bits 16i+15..16i. It shifts each lane left by the scale, then arithmetically right by 7, and clamps it to 0..255. Lane i goes to result byte i.
- R3: The 16-bit pack uses only the low four bits of the scale input (status bits 6..3). Scale bit 4 has no effect on it.
- R4: The 32-bit pack treats rs2 as two signed 32-bit lanes. It shifts each lane left by the full 5-bit scale, then arithmetically right by 23, and clamps it to 0..255. Lane 0 is written to result byte 0 and lane 1 to result byte 4.
- R5: The 32-bit pack fills all other result bytes from rs1 shifted left by 8 bits. The bytes of rs1 that would land in bytes 0 and 4 are replaced.
- R6: The fixed pack treats rs2 as two signed 32-bit lanes. It shifts each lane left by the full 5-bit scale, then arithmetically right by 16, and saturates it to -32768..32767. Lane 0 goes to result bits 15..0 and lane 1 to bits 31..16.
- R7: The scaled values never wrap. A scale of 31 applied to any 32-bit lane still clamps or saturates correctly.
- R8: Expand takes bytes 0..3 of rs2 as unsigned values and shifts each left by 4. Byte i goes to 16-bit result lane i, so bits 15..12 and 3..0 of every lane are zero.
- R9: Merge builds result byte 2i from rs2 byte i and result byte 2i+1 from rs1 byte i, for i = 0..3.
- R10: `valid_o` is high exactly in the cycle after a start pulse. Without a start, `result_o` keeps its value.
- R11: An illegal code gives a zero result and raises `illegal_o` together with `valid_o`. Legal codes leave `illegal_o` low.
- R12: The 16-bit pack and the fixed pack clear result bits 63..32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; loads the operation |
| op_i | input | 9 | Operation code |
| rs1_i | input | 64 | First source operand |
| rs2_i | input | 64 | Second source operand |
| scale_i | input | 5 | Scale field of the graphics status register (bits 7..3) |
| result_o | output | 64 | Registered result |
| valid_o | output | 1 | One-cycle result-valid pulse |
| illegal_o | output | 1 | One-cycle illegal-code flag |

## Verification
The bench builds the unit with its default 64-bit word and 5-bit scale field. With these values every scale setting is within reach of a full sweep: all 16 settings for the 16-bit pack, each tried with scale bit 4 both clear and set, and all 32 settings for the two word packs. The lane stimulus is a mix of edge values (zero, ±1, the largest and smallest signed values, values right at the clamp limits) and pseudo-random data. All 256 byte values pass through expand, and all 512 operation codes are visited, so every illegal code is covered.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;

    localparam int WORD_W  = 64;
    localparam int HALF_W  = WORD_W / 2;
    localparam int OP_W    = 9;
    localparam int SCALE_W = 5;
    // Signed intermediate width: 32-bit lane plus largest shift (31) fits.
    localparam int WIDE_W  = 64;

    typedef enum logic [OP_W-1:0] {
        OP_PACK16  = 9'h03b,
        OP_PACK32  = 9'h03a,
        OP_PACKFIX = 9'h03d,
        OP_EXPAND  = 9'h04d,
        OP_MERGE   = 9'h04b
    } pxop_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              bad;
    } pxres_t;

    localparam logic signed [WIDE_W-1:0] U8_HI  = 255;
    localparam logic signed [WIDE_W-1:0] S16_HI = 32767;
    localparam logic signed [WIDE_W-1:0] S16_LO = -32768;

    function automatic logic [7:0] sat_u8(input logic signed [WIDE_W-1:0] v);
        if (v < 0)          return 8'h00;
        else if (v > U8_HI) return 8'hff;
        else                return v[7:0];
    endfunction

    function automatic logic [15:0] sat_s16(input logic signed [WIDE_W-1:0] v);
        if (v < S16_LO)      return 16'h8000;
        else if (v > S16_HI) return 16'h7fff;
        else                 return v[15:0];
    endfunction

endpackage

// File: rtl/pxfmt_pack16.sv
module pxfmt_pack16
    import pxfmt_pkg::*;
#(
    parameter int DW   = WORD_W,
    parameter int SW   = SCALE_W - 1,
    parameter int BPT  = 7
) (
    input  logic [DW-1:0]   src_i,
    input  logic [SW-1:0]   scale_i,
    output logic [DW/2-1:0] pack_o
);
    localparam int LANES = DW / 16;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [15:0]       lane;
        logic signed [WIDE_W-1:0] ext, scaled, shr;
        assign lane   = src_i[16*i +: 16];
        assign ext    = WIDE_W'(lane);
        assign scaled = ext <<< scale_i;
        assign shr    = scaled >>> BPT;
        assign pack_o[8*i +: 8] = sat_u8(shr);
    end

endmodule

// File: rtl/pxfmt_packw.sv
module pxfmt_packw
    import pxfmt_pkg::*;
#(
    parameter int DW      = WORD_W,
    parameter int SW      = SCALE_W,
    parameter int BPT_U8  = 23,
    parameter int BPT_FIX = 16
) (
    input  logic [DW-1:0]   keep_i,
    input  logic [DW-1:0]   src_i,
    input  logic [SW-1:0]   scale_i,
    output logic [DW-1:0]   pk32_o,
    output logic [DW/2-1:0] fix_o
);
    localparam int LANES = DW / 32;
    localparam logic [DW-1:0] KEEP_MASK = {LANES{32'hffff_ff00}};

    logic [DW-1:0] ins;

    // One shifter per lane feeds both the byte pack and the fixed pack.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [31:0]       lane;
        logic signed [WIDE_W-1:0] ext, scaled, shr_u8, shr_fix;
        assign lane    = src_i[32*i +: 32];
        assign ext     = WIDE_W'(lane);
        assign scaled  = ext <<< scale_i;
        assign shr_u8  = scaled >>> BPT_U8;
        assign shr_fix = scaled >>> BPT_FIX;
        assign ins[32*i +: 32]  = {24'h0, sat_u8(shr_u8)};
        assign fix_o[16*i +: 16] = sat_s16(shr_fix);
    end

    assign pk32_o = ((keep_i << 8) & KEEP_MASK) | ins;

endmodule

// File: rtl/pxfmt_spread.sv
module pxfmt_spread
    import pxfmt_pkg::*;
#(
    parameter int HW = HALF_W
) (
    input  logic [HW-1:0]   lo_a_i,
    input  logic [HW-1:0]   lo_b_i,
    output logic [2*HW-1:0] expand_o,
    output logic [2*HW-1:0] merge_o
);
    localparam int BYTES = HW / 8;

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        assign expand_o[16*i +: 16] = {4'h0, lo_b_i[8*i +: 8], 4'h0};
        assign merge_o[16*i +: 16]  = {lo_a_i[8*i +: 8], lo_b_i[8*i +: 8]};
    end

endmodule

// File: rtl/pxfmt_unit.sv
module pxfmt_unit
    import pxfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [WORD_W-1:0] rs1_i,
    input  logic [WORD_W-1:0] rs2_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [WORD_W-1:0] result_o,
    output logic              valid_o,
    output logic              illegal_o
);
    logic [HALF_W-1:0] p16, pfix;
    logic [WORD_W-1:0] p32, pexp, pmrg;
    pxres_t            nxt;

    pxfmt_pack16 #(.DW(WORD_W), .SW(SCALE_W-1)) u_pack16 (
        .src_i   (rs2_i),
        .scale_i (scale_i[SCALE_W-2:0]),
        .pack_o  (p16)
    );

    pxfmt_packw #(.DW(WORD_W), .SW(SCALE_W)) u_packw (
        .keep_i  (rs1_i),
        .src_i   (rs2_i),
        .scale_i (scale_i),
        .pk32_o  (p32),
        .fix_o   (pfix)
    );

    pxfmt_spread #(.HW(HALF_W)) u_spread (
        .lo_a_i   (rs1_i[HALF_W-1:0]),
        .lo_b_i   (rs2_i[HALF_W-1:0]),
        .expand_o (pexp),
        .merge_o  (pmrg)
    );

    always_comb begin
        nxt = '0;
        case (op_i)
            OP_PACK16:  nxt.data = WORD_W'(p16);
            OP_PACK32:  nxt.data = p32;
            OP_PACKFIX: nxt.data = WORD_W'(pfix);
            OP_EXPAND:  nxt.data = pexp;
            OP_MERGE:   nxt.data = pmrg;
            default:    nxt.bad  = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o  <= '0;
            valid_o   <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            valid_o   <= start_i;
            illegal_o <= start_i & nxt.bad;
            if (start_i) result_o <= nxt.data;
        end
    end

endmodule

// File: rtl/pxfmt_unit_chk.sv
module pxfmt_unit_chk
    import pxfmt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic [OP_W-1:0]    op_i,
    input logic [WORD_W-1:0]  rs1_i,
    input logic [WORD_W-1:0]  rs2_i,
    input logic [SCALE_W-1:0] scale_i,
    input logic [WORD_W-1:0]  result_o,
    input logic               valid_o,
    input logic               illegal_o
);
    localparam logic [WORD_W-1:0] EXP_ZERO_NIB = 64'hf00f_f00f_f00f_f00f;

    p_valid_after_start_r10: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o);

    p_hold_without_start_r10: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (!valid_o && $stable(result_o)));

    p_illegal_zero_r11: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (valid_o && result_o == '0));

    p_expand_nibbles_r8: assert property (@(posedge clk) disable iff (rst)
        (start_i && op_i == OP_EXPAND) |=> ((result_o & EXP_ZERO_NIB) == '0));

    p_upper_clear_r12: assert property (@(posedge clk) disable iff (rst)
        (start_i && (op_i == OP_PACK16 || op_i == OP_PACKFIX))
        |=> (result_o[WORD_W-1:HALF_W] == '0));

    p_keep_rs1_r5: assert property (@(posedge clk) disable iff (rst)
        (start_i && op_i == OP_PACK32)
        |=> (result_o[31:8] == $past(rs1_i[23:0]) &&
             result_o[63:40] == $past(rs1_i[55:32])));

    p_merge_ends_r9: assert property (@(posedge clk) disable iff (rst)
        (start_i && op_i == OP_MERGE)
        |=> (result_o[7:0] == $past(rs2_i[7:0]) &&
             result_o[63:56] == $past(rs1_i[31:24])));

    p_legal_no_flag_r1: assert property (@(posedge clk) disable iff (rst)
        (start_i && (op_i == OP_PACK16 || op_i == OP_PACK32 ||
                     op_i == OP_PACKFIX || op_i == OP_EXPAND ||
                     op_i == OP_MERGE)) |=> !illegal_o);

endmodule

bind pxfmt_unit pxfmt_unit_chk u_chk (.*);

// File: tb/pxfmt_unit_bench.sv
module pxfmt_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [8:0]  op = '0;
    logic [63:0] rs1 = '0, rs2 = '0;
    logic [4:0]  scale = '0;
    logic [63:0] result;
    logic        valid, illegal;

    int n_checks = 0;
    int n_fail   = 0;
    longint unsigned seed = 64'h1234_5678_9abc_def1;

    always #5 clk = ~clk;

    pxfmt_unit u_pxfmt_unit (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op),
        .rs1_i(rs1), .rs2_i(rs2), .scale_i(scale),
        .result_o(result), .valid_o(valid), .illegal_o(illegal)
    );

    function automatic longint unsigned rnd();
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        return seed ^ (seed >> 29);
    endfunction

    function automatic logic [15:0] edge16(int k);
        case (k % 10)
            0: return 16'h0000; 1: return 16'h0001; 2: return 16'h7fff;
            3: return 16'h8000; 4: return 16'hffff; 5: return 16'h0080;
            6: return 16'h00ff; 7: return 16'h0100; 8: return 16'h4000;
            default: return 16'hff80;
        endcase
    endfunction

    function automatic logic [31:0] edge32(int k);
        case (k % 10)
            0: return 32'h0000_0000; 1: return 32'h0000_0001; 2: return 32'h7fff_ffff;
            3: return 32'h8000_0000; 4: return 32'hffff_ffff; 5: return 32'h0080_0000;
            6: return 32'h7f80_0000; 7: return 32'h0001_0000; 8: return 32'h7fff_0000;
            default: return 32'hffff_8000;
        endcase
    endfunction

    function automatic longint clampl(longint v, longint lo, longint hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic logic [63:0] m_pack16(logic [63:0] b, int sc);
        logic [63:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            longint s = longint'($signed(b[16*i +: 16]));
            s = (s * (longint'(1) << sc)) >>> 7;
            r[8*i +: 8] = 8'(clampl(s, 0, 255));
        end
        return r;
    endfunction

    function automatic logic [63:0] m_pack32(logic [63:0] a, logic [63:0] b, int sc);
        logic [63:0] r = (a << 8) & 64'hffff_ff00_ffff_ff00;
        for (int i = 0; i < 2; i++) begin
            longint s = longint'($signed(b[32*i +: 32]));
            s = (s * (longint'(1) << sc)) >>> 23;
            r = r | (64'(clampl(s, 0, 255)) << (32 * i));
        end
        return r;
    endfunction

    function automatic logic [63:0] m_fix(logic [63:0] b, int sc);
        logic [63:0] r = '0;
        for (int i = 0; i < 2; i++) begin
            longint s = longint'($signed(b[32*i +: 32]));
            s = (s * (longint'(1) << sc)) >>> 16;
            r[16*i +: 16] = 16'(clampl(s, -32768, 32767));
        end
        return r;
    endfunction

    function automatic logic [63:0] m_expand(logic [63:0] b);
        logic [63:0] r = '0;
        for (int i = 0; i < 4; i++) r = r | ((64'(b[8*i +: 8]) * 16) << (16 * i));
        return r;
    endfunction

    function automatic logic [63:0] m_merge(logic [63:0] a, logic [63:0] b);
        logic [63:0] r = '0;
        for (int i = 0; i < 8; i++)
            r[8*i +: 8] = (i % 2 == 0) ? b[8*(i/2) +: 8] : a[8*(i/2) +: 8];
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called just after a falling edge; returns just after a falling edge.
    task automatic run_op(logic [8:0] o, logic [63:0] a, logic [63:0] b,
                          logic [4:0] sc, logic [63:0] exp, bit exp_ill, string req);
        logic [63:0] held;
        op = o; rs1 = a; rs2 = b; scale = sc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rs1 = ~a; rs2 = ~b;
        check(result == exp, req, result, exp);
        check(valid == 1'b1, "R10 valid", 64'(valid), 64'd1);
        check(illegal == exp_ill, "R11/R1 illegal flag", 64'(illegal), 64'(exp_ill));
        held = result;
        @(negedge clk);
        check(valid == 1'b0 && result == held, "R10 hold", result, held);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(result == '0 && valid == 1'b0 && illegal == 1'b0,
              "reset state", result, 64'd0);

        // R2 / R3 / R12: 16-bit pack over all 4-bit scales, bit 4 both ways
        for (int sc = 0; sc < 16; sc++)
            for (int hi = 0; hi < 2; hi++)
                for (int k = 0; k < 12; k++) begin
                    logic [63:0] b = (k < 10) ?
                        {edge16(k), edge16(k + 3), edge16(k + 5), edge16(k + 7)} : rnd();
                    run_op(9'h03b, rnd(), b, 5'(hi * 16 + sc),
                           m_pack16(b, sc), 1'b0, "R2 R3 R12 pack16");
                end

        // R4 / R5 / R7: 32-bit pack over all scales
        for (int sc = 0; sc < 32; sc++)
            for (int k = 0; k < 12; k++) begin
                logic [63:0] a = rnd();
                logic [63:0] b = (k < 10) ? {edge32(k), edge32(k + 4)} : rnd();
                run_op(9'h03a, a, b, 5'(sc), m_pack32(a, b, sc), 1'b0, "R4 R5 R7 pack32");
            end

        // R6 / R7 / R12: fixed pack over all scales
        for (int sc = 0; sc < 32; sc++)
            for (int k = 0; k < 12; k++) begin
                logic [63:0] b = (k < 10) ? {edge32(k + 2), edge32(k)} : rnd();
                run_op(9'h03d, rnd(), b, 5'(sc), m_fix(b, sc), 1'b0, "R6 R7 R12 fixed pack");
            end

        // R8: every byte value in every lane
        for (int v = 0; v < 256; v++) begin
            logic [63:0] b = {rnd() >> 32, 8'(v), 8'(v + 85), 8'(255 - v), 8'(v * 7)};
            run_op(9'h04d, rnd(), b, 5'(v), m_expand(b), 1'b0, "R8 expand");
        end

        // R9: merge
        for (int k = 0; k < 64; k++) begin
            logic [63:0] a = rnd();
            logic [63:0] b = rnd();
            run_op(9'h04b, a, b, 5'(k), m_merge(a, b), 1'b0, "R9 merge");
        end

        // R1 / R11: every other code is illegal
        for (int c = 0; c < 512; c++) begin
            if (c != 'h03b && c != 'h03a && c != 'h03d && c != 'h04d && c != 'h04b)
                run_op(9'(c), rnd() | 64'h1, rnd() | 64'h1, 5'(c), 64'd0, 1'b1,
                       "R1 R11 illegal code");
        end

        finish_run();
    end

endmodule